// File: doc/BRIEF.md
# Receive FIFO with Request-to-Send Generation

This block buffers bytes coming out of a UART receive deserializer and drives the active-low request-to-send pin that tells the remote transmitter whether it may keep sending. Each byte offered on the write strobe is stored in first-in, first-out order. The host takes bytes off the head with a read strobe. The head byte is always presented on the read data port, so a read strobe simply advances to the next entry.

In hardware mode the pin is driven from the occupancy count. A threshold selector chooses a fraction of the FIFO depth. The pin is held low while fewer bytes than that threshold are stored. It goes high as soon as the count reaches the threshold, and it drops back low once reads bring the count below it. In software mode the pin simply copies a control bit and ignores the fill level. Received bytes keep being accepted until the FIFO is full. A byte that arrives while the FIFO is full is dropped and raises a sticky overrun flag.

Top module: `rx_fifo_rts`

## Requirements
- R1: After a synchronous active-low reset the FIFO is empty: `empty`=1, `full`=0, `level`=0, `overrun`=0, and with `hw_rts_en`=1 the pin `rts_n` is 0.
- R2: Bytes leave in the order they were accepted, and `rd_data` shows the oldest stored byte whenever `empty` is 0.
- R3: `level` rises by one for each accepted write and falls by one for each read while not empty; a read while empty is ignored and `level` stays 0.
- R4: A read and a write in the same cycle while 0 < `level` < DEPTH leave `level` unchanged.
- R5: `full` is 1 exactly when `level` equals DEPTH; a write while full is discarded and the stored contents are unchanged.
- R6: A discarded write sets `overrun`, which stays set until a cycle with `ovr_clr`=1; if a discarded write and `ovr_clr` coincide, `overrun` is set.
- R7: `trig_sel` encodes the threshold: 0 → DEPTH/8, 1 → DEPTH/4, 2 → DEPTH/2, 3 → 3·DEPTH/4, and 4 to 7 → 7·DEPTH/8 (2, 4, 8, 12, 14 for DEPTH 16).
- R8: With `hw_rts_en`=1, `rts_n` is 0 while `level` is below the threshold and 1 while it is at or above it. The pin changes in the same cycle that `level` shows the write that reaches the threshold.
- R9: With `hw_rts_en`=1, `rts_n` returns to 0 in the same cycle that `level` first shows a value below the threshold after reads.
- R10: With `hw_rts_en`=0, `rts_n` equals `sw_rts` whatever the value of `level`.
- R11: With `hw_rts_en`=1, the value of `sw_rts` has no effect on `rts_n`.
- R12: With `hw_rts_en`=0, writes are accepted past the threshold until `level` reaches DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe from the deserializer |
| wr_data | input | DATA_W | Received byte |
| rd_en | input | 1 | Host read strobe, pops the head byte |
| rd_data | output | DATA_W | Head byte of the FIFO |
| trig_sel | input | 3 | Threshold encoding for hardware RTS |
| hw_rts_en | input | 1 | 1: pin follows occupancy; 0: pin follows `sw_rts` |
| sw_rts | input | 1 | Pin value used in software mode |
| ovr_clr | input | 1 | Clears the overrun flag |
| empty | output | 1 | No bytes stored |
| full | output | 1 | DEPTH bytes stored |
| level | output | ADDR_W+1 | Occupancy count |
| overrun | output | 1 | Sticky dropped-write flag |
| rts_n | output | 1 | Active-low request-to-send pin |

## Verification
A table of mixed writes, reads and combined read-writes at the mid threshold runs first. It separates the case where the count crosses the threshold upward from the case where it crosses downward, and it separates a combined read-write from a lone read or write. A sweep over every threshold code fills the FIFO to one below the threshold and then to the threshold itself, which shows an off-by-one in either the encoding or the comparison. Filling to capacity in software mode, writing while full, and toggling the mode with the software bit opposite to the hardware result show whether the mode select, the drop path and the overrun flag each act on their own.

// File: rtl/rxf_pkg.sv
// Shared helpers for the receive FIFO.
// Assumes a FIFO depth of at least 8, so that every threshold is non-zero.
package rxf_pkg;

    localparam int unsigned TSEL_W = 3;

    // Maps a threshold code onto an entry count for a FIFO of the given depth.
    function automatic int unsigned trig_count(input logic [TSEL_W-1:0] sel,
                                               input int unsigned depth);
        case (sel)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd2:    return depth / 2;
            3'd3:    return (depth * 3) / 4;
            default: return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
// Storage array with read and write pointers for the receive FIFO.
// Assumes push and pop were already qualified by full and empty.
// The head entry is shown combinationally on rd_data.
module rxf_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [DATA_W-1:0] slot [DEPTH];

    // Advance the pointers on qualified push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // One write-enabled register per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == ADDR_W'(i))) slot[i] <= wr_data;
        end
    end

    // Present the head entry.
    assign rd_data = slot[rd_ptr];

endmodule

// File: rtl/rxf_count.sv
// Occupancy counter, empty/full flags and sticky overrun flag.
// Assumes the requests come straight from the ports. It qualifies them into
// push/pop for the storage array. A write while full is dropped even when a
// read occurs in the same cycle.
module rxf_count #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic            rd_req,
    input  logic            ovr_clr,
    output logic            push,
    output logic            pop,
    output logic [ADDR_W:0] level,
    output logic            empty,
    output logic            full,
    output logic            overrun
);
    localparam int unsigned LVL_W = ADDR_W + 1;
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(1 << ADDR_W);

    // Qualify the requests against the current flags.
    assign push  = wr_req && !full;
    assign pop   = rd_req && !empty;
    assign empty = (level == '0);
    assign full  = (level == DEPTH_L);

    // Track the occupancy; a combined push and pop cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)             level <= '0;
        else if (push && !pop)  level <= level + 1'b1;
        else if (pop && !push)  level <= level - 1'b1;
    end

    // Sticky overrun: a dropped write sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  overrun <= 1'b0;
        else if (wr_req && full)     overrun <= 1'b1;
        else if (ovr_clr)            overrun <= 1'b0;
    end

    // R3
    fill_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_L);

    // R3
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_req && !wr_req |=> empty);

    // R4
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && wr_req && !empty && !full |=> $stable(level));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_req && !rd_req |=> full);

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_req |=> overrun);

endmodule

// File: rtl/rxf_rts.sv
// Request-to-send pin generation.
// Assumes level is the registered occupancy. The pin is combinational from
// it, so the pin moves in the same cycle as the count.
module rxf_rts #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W:0]           level,
    input  logic [rxf_pkg::TSEL_W-1:0] trig_sel,
    input  logic                      hw_en,
    input  logic                      sw_rts,
    output logic                      rts_n
);
    localparam int unsigned LVL_W = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [LVL_W-1:0] thresh;
    logic             at_trig;

    // Decode the threshold code and compare it with the count.
    always_comb begin
        thresh  = LVL_W'(rxf_pkg::trig_count(trig_sel, DEPTH));
        at_trig = (level >= thresh);
    end

    // Choose hardware or software control of the pin.
    assign rts_n = hw_en ? at_trig : sw_rts;

    // R10
    sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en && $stable(sw_rts) && $stable(hw_en) |-> $stable(rts_n));

endmodule

// File: rtl/rx_fifo_rts.sv
// Receive FIFO with an active-low request-to-send output.
// Assumes DEPTH = 2**ADDR_W >= 8. Reset is synchronous and active low.
module rx_fifo_rts #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [2:0]        trig_sel,
    input  logic              hw_rts_en,
    input  logic              sw_rts,
    input  logic              ovr_clr,
    output logic              empty,
    output logic              full,
    output logic [ADDR_W:0]   level,
    output logic              overrun,
    output logic              rts_n
);
    logic push;
    logic pop;

    // Occupancy and flags.
    rxf_count #(.ADDR_W(ADDR_W)) u_count (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .rd_req(rd_en),
        .ovr_clr(ovr_clr), .push(push), .pop(pop), .level(level),
        .empty(empty), .full(full), .overrun(overrun)
    );

    // Data storage.
    rxf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    // Pin generation.
    rxf_rts #(.ADDR_W(ADDR_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .level(level), .trig_sel(trig_sel),
        .hw_en(hw_rts_en), .sw_rts(sw_rts), .rts_n(rts_n)
    );

    // R8
    empty_rts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rts_en && empty |-> !rts_n);

    // R8
    full_rts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rts_en && full |-> rts_n);

endmodule

// File: tb/rx_fifo_rts_test.sv
module rx_fifo_rts_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] trig_sel = 3'd2;
    logic       hw_rts_en = 1'b1;
    logic       sw_rts = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       empty, full, overrun, rts_n;
    logic [4:0] level;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rx_fifo_rts uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .trig_sel(trig_sel),
        .hw_rts_en(hw_rts_en), .sw_rts(sw_rts), .ovr_clr(ovr_clr),
        .empty(empty), .full(full), .level(level), .overrun(overrun),
        .rts_n(rts_n)
    );

    // {wr, rd, din, level after, rts_n after, head byte after}; trig_sel=2 -> 8
    localparam logic [23:0] VEC [16] = '{
        {1'b1, 1'b0, 8'hA0, 5'd1, 1'b0, 8'hA0},
        {1'b1, 1'b0, 8'hA1, 5'd2, 1'b0, 8'hA0},
        {1'b1, 1'b0, 8'hA2, 5'd3, 1'b0, 8'hA0},
        {1'b1, 1'b0, 8'hA3, 5'd4, 1'b0, 8'hA0},
        {1'b1, 1'b0, 8'hA4, 5'd5, 1'b0, 8'hA0},
        {1'b1, 1'b0, 8'hA5, 5'd6, 1'b0, 8'hA0},
        {1'b1, 1'b0, 8'hA6, 5'd7, 1'b0, 8'hA0},
        {1'b1, 1'b0, 8'hA7, 5'd8, 1'b1, 8'hA0},
        {1'b0, 1'b1, 8'h00, 5'd7, 1'b0, 8'hA1},
        {1'b1, 1'b0, 8'hA8, 5'd8, 1'b1, 8'hA1},
        {1'b1, 1'b1, 8'hA9, 5'd8, 1'b1, 8'hA2},
        {1'b0, 1'b1, 8'h00, 5'd7, 1'b0, 8'hA3},
        {1'b0, 1'b1, 8'h00, 5'd6, 1'b0, 8'hA4},
        {1'b1, 1'b1, 8'hAA, 5'd6, 1'b0, 8'hA5},
        {1'b0, 1'b1, 8'h00, 5'd5, 1'b0, 8'hA6},
        {1'b0, 1'b0, 8'h00, 5'd5, 1'b0, 8'hA6}
    };

    function automatic int exp_trig(input int s);
        case (s)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 12;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of strobes; returns #1 after the edge.
    task automatic step(input logic w, input logic r, input logic [7:0] d);
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 level", 32'(level), 0);
        chk("R1 overrun", 32'(overrun), 0);
        chk("R1 rts_n", 32'(rts_n), 0);
        rst_n = 1'b1;
        step(0, 0, 8'h00);

        // Table walk: R2 order, R3 counting, R4 combined, R8/R9 crossings
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][23], VEC[i][22], VEC[i][21:14]);
            chk("R3/R4 level", 32'(level), 32'(VEC[i][13:9]));
            chk("R8/R9 rts_n", 32'(rts_n), 32'(VEC[i][8]));
            chk("R2 head", 32'(rd_data), 32'(VEC[i][7:0]));
        end

        // R2 drain the rest in order
        for (int i = 0; i < 5; i++) begin
            chk("R2 drain order", 32'(rd_data), 32'(8'hA6 + i));
            step(0, 1, 8'h00);
        end
        chk("R3 empty after drain", 32'(empty), 1);
        // R3 read on empty ignored
        step(0, 1, 8'h00);
        chk("R3 read empty level", 32'(level), 0);

        // R7/R8/R9 threshold sweep
        for (int s = 0; s < 8; s++) begin
            int t;
            trig_sel = 3'(s);
            t = exp_trig(s);
            for (int i = 0; i < t - 1; i++) step(1, 0, 8'(i));
            chk("R7 below threshold rts_n", 32'(rts_n), 0);
            step(1, 0, 8'h55);
            chk("R7 at threshold rts_n", 32'(rts_n), 1);
            step(0, 1, 8'h00);
            chk("R9 back below rts_n", 32'(rts_n), 0);
            for (int i = 0; i < t - 1; i++) step(0, 1, 8'h00);
            chk("R7 drained", 32'(level), 0);
        end

        // R10 software mode
        trig_sel = 3'd0;
        hw_rts_en = 1'b0;
        sw_rts = 1'b1;
        #1;
        chk("R10 sw high", 32'(rts_n), 1);
        sw_rts = 1'b0;
        #1;
        chk("R10 sw low", 32'(rts_n), 0);
        // R12 accepted until full
        for (int i = 0; i < 16; i++) step(1, 0, 8'(8'h40 + i));
        chk("R12 level at depth", 32'(level), 16);
        chk("R5 full flag", 32'(full), 1);
        chk("R10 level has no effect", 32'(rts_n), 0);
        // R5/R6 write while full
        step(1, 0, 8'hEE);
        chk("R5 level after drop", 32'(level), 16);
        chk("R6 overrun set", 32'(overrun), 1);
        step(0, 0, 8'h00);
        chk("R6 overrun sticky", 32'(overrun), 1);
        ovr_clr = 1'b1;
        step(0, 0, 8'h00);
        chk("R6 overrun cleared", 32'(overrun), 0);
        step(1, 0, 8'hEF);
        chk("R6 set wins over clear", 32'(overrun), 1);
        ovr_clr = 1'b0;

        // R11 hardware mode ignores sw bit
        hw_rts_en = 1'b1;
        #1;
        chk("R11 hw full sw0", 32'(rts_n), 1);
        chk("R5 head unchanged", 32'(rd_data), 32'h40);
        for (int i = 0; i < 16; i++) begin
            chk("R2 order after full", 32'(rd_data), 32'(8'h40 + i));
            step(0, 1, 8'h00);
        end
        sw_rts = 1'b1;
        #1;
        chk("R11 hw empty sw1", 32'(rts_n), 0);

        // R1 reset mid-fill
        for (int i = 0; i < 3; i++) step(1, 0, 8'(i));
        rst_n = 1'b0;
        step(0, 0, 8'h00);
        rst_n = 1'b1;
        chk("R1 reset empties", 32'(empty), 1);
        chk("R1 reset level", 32'(level), 0);
        chk("R1 reset rts_n", 32'(rts_n), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule